// File: doc/BRIEF.md
# Transmit Short-Circuit Retry Controller

This block sits between the bipolar line encoder and the line driver of a transmitter, and it guards the driver against a short. The driver's analog sensing reports a short on a single detect input. The short may be from either output to the supply, from either output to ground, or between the two outputs. The block brings that input into the transmit clock domain. When a short is seen, it turns the driver off for a fixed protection window of transmit clock cycles.

When the window ends, the driver is switched back on and sends whatever symbol the encoder presents in that cycle. If the short is still present during that retry symbol, the block enters a new protection window. This loop repeats until a retry symbol goes out cleanly, and normal driving then resumes. The block does not latch the fault. A short-alarm flag is kept for use inside the chip only.

Symbols are two bits wide, written {sign, mark}. 2'b01 is +1, 2'b11 is -1, 2'b00 is zero, and the unused code 2'b10 is treated as zero.

Top module: `tx_short_guard`

## Requirements
- R1: In the cycle after the synchronised short indication is seen while driving normally, drv_en goes low and short_alarm goes high.
- R2: Each protection window keeps drv_en low for exactly PROT_CYCLES (default 35) consecutive clock cycles.
- R3: After the window, drv_en is high for a retry cycle, and sym_out carries the sym_in value applied in that cycle.
- R4: If the synchronised short is still present during the retry cycle, a new full protection window starts in the next cycle, and short_alarm stays high.
- R5: While driving, sym_out follows sym_in in the same cycle for 2'b00, 2'b01 and 2'b11, and it outputs 2'b00 for the unused code 2'b10.
- R6: While drv_en is low, sym_out is 2'b00 whatever sym_in is, so symbols offered during protection are dropped.
- R7: A retry cycle with no synchronised short clears short_alarm and returns the block to normal driving.
- R8: Asserting rst_n low, including during protection, gives drv_en high, short_alarm low and a cleared window counter.
- R9: short_raw passes through SYNC_STAGES (default 2) flip-flops. A short first sampled at edge k disables the driver only after edge k+SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_raw | input | 1 | Short-detect level from the driver stage, asynchronous |
| sym_in | input | 2 | Next symbol from the encoder, {sign, mark} |
| drv_en | output | 1 | Line driver enable |
| sym_out | output | 2 | Symbol to drive, {sign, mark} |
| short_alarm | output | 1 | Internal short-alarm flag |

## Verification
The assertions assume that short_raw is a level that stays put for at least one clock cycle. They also assume that sym_in changes only between clock edges, so that the synchronised indication and the retry symbol are well defined in each cycle. The bench drives both inputs on the falling edge and holds a short either for one whole cycle or across several windows. It releases a short well inside a protection window, so the retry that follows sees a clean, synchronised level. It never changes an input in the same instant as the rising edge it is meant to meet.

// File: rtl/tx_short_guard.sv
module tx_short_guard #(
  parameter int PROT_CYCLES = 35,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       short_raw,
  input  logic [1:0] sym_in,
  output logic       drv_en,
  output logic [1:0] sym_out,
  output logic       short_alarm
);
  localparam int CW = (PROT_CYCLES > 1) ? $clog2(PROT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PROT_CYCLES - 1);

  typedef enum logic [1:0] {ST_RUN, ST_PROT, ST_RETRY} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                 short_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], short_raw};

  assign short_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_RUN;
      cnt         <= '0;
      short_alarm <= 1'b0;
    end else begin
      unique case (st)
        ST_RUN: if (short_s) begin
          st          <= ST_PROT;
          cnt         <= '0;
          short_alarm <= 1'b1;
        end
        ST_PROT: if (cnt == LAST) st <= ST_RETRY;
                 else             cnt <= cnt + 1'b1;
        ST_RETRY: begin
          cnt <= '0;
          if (short_s) st <= ST_PROT;
          else begin
            st          <= ST_RUN;
            short_alarm <= 1'b0;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign drv_en  = (st != ST_PROT);
  assign sym_out = (drv_en && sym_in[0]) ? sym_in : 2'b00;

  // R1
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && short_s) |=> (!drv_en && short_alarm));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && cnt != LAST) |=> !drv_en);
  // R3
  reen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en && cnt == LAST) |=> (drv_en && short_alarm));
  // R4
  again_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RETRY && short_s) |=> (!drv_en && short_alarm && cnt == '0));
  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (sym_out == 2'b00));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RETRY && !short_s) |=> (drv_en && !short_alarm));
endmodule

// File: tb/tx_short_guard_tb_top.sv
module tx_short_guard_tb_top;
  localparam int PROT = 35;

  logic clk = 1'b0, rst_n = 1'b0, short_raw = 1'b0;
  logic [1:0] sym_in = 2'b00;
  logic drv_en, short_alarm;
  logic [1:0] sym_out;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tx_short_guard #(.PROT_CYCLES(PROT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .short_raw(short_raw), .sym_in(sym_in),
    .drv_en(drv_en), .sym_out(sym_out), .short_alarm(short_alarm));

  // {sym_in, expected sym_out} while driving
  localparam logic [3:0] VEC [6] = '{4'b01_01, 4'b11_11, 4'b00_00,
                                     4'b10_00, 4'b01_01, 4'b11_11};

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts low negedges until drv_en high; toggles sym_in meanwhile
  task automatic low_window(output int n);
    n = 0;
    while (!drv_en && n < 100) begin
      chk("R6 sym_out quiet", sym_out, 0);
      n++;
      sym_in = n[0] ? 2'b01 : 2'b11;
      @(negedge clk);
    end
  endtask

  initial begin
    int w;
    @(negedge clk);
    chk("R8 reset drv_en", drv_en, 1);
    chk("R8 reset alarm", short_alarm, 0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      sym_in = VEC[i][3:2];
      #1;
      chk("R5 pass-through", sym_out, VEC[i][1:0]);
      chk("R5 drv_en", drv_en, 1);
    end

    // single one-cycle short
    @(negedge clk);
    short_raw = 1'b1; sym_in = 2'b01;
    @(negedge clk);
    short_raw = 1'b0;
    chk("R9 sync edge1", drv_en, 1);
    @(negedge clk);
    chk("R9 sync edge2", drv_en, 1);
    @(negedge clk);
    chk("R1 drv_en off", drv_en, 0);
    chk("R1 alarm on", short_alarm, 1);
    low_window(w);
    chk("R2 window length", w, PROT);
    #1;
    chk("R3 retry drv_en", drv_en, 1);
    chk("R3 retry symbol", sym_out, sym_in);
    chk("R3 alarm held in retry", short_alarm, 1);
    @(negedge clk);
    chk("R7 alarm cleared", short_alarm, 0);
    chk("R7 driving", drv_en, 1);

    // persistent short
    short_raw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 persistent entry", drv_en, 0);
    low_window(w);
    chk("R2 first window", w, PROT);
    chk("R3 retry cycle", drv_en, 1);
    @(negedge clk);
    chk("R4 re-protect", drv_en, 0);
    chk("R4 alarm held", short_alarm, 1);
    repeat (10) @(negedge clk);
    short_raw = 1'b0;
    low_window(w);
    chk("R4 second window", w, PROT - 10);
    sym_in = 2'b11;
    #1;
    chk("R3 retry symbol -1", sym_out, 2'b11);
    @(negedge clk);
    chk("R7 clear after retry", short_alarm, 0);
    chk("R7 stays driving", drv_en, 1);

    // reset during protection
    short_raw = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 entry before reset", drv_en, 0);
    short_raw = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8 reset drv_en", drv_en, 1);
    chk("R8 reset alarm", short_alarm, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 no stale fault", drv_en, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule